// File: doc/BRIEF.md
# Coalescing Second-Tier ECC Log Writer

The last-level cache keeps only a light detection code next to each line. The strong correction code for every dirty line is kept off-chip. Each time a dirty line is written into the cache, an upstream encoder hands this block one record: the line tag and its strong code. The block packs these records into a small coalesce buffer. When the buffer holds one memory burst's worth of records, it emits them as a single burst write into a circular log in external memory. The log is a write-through ring. New bursts overwrite the oldest slot, and the ring never stalls.

When a line fails its light check, the correction logic asks this block for the strong code of that tag. The block searches the coalesce buffer first, newest record first. It then reads log slots through its read port, walking backward from the slot written most recently. It stops at the first matching record. If the record has aged out of the ring, it answers not-found.

Top module: `ecc_log_coalescer`

## Requirements
- R1: While reset is held and after it is released, with no stimulus, `wr_vld`, `rd_req`, `lk_busy` and `lk_done` are all low.
- R2: After `RECS` accepted pushes, exactly one burst write appears, in the cycle after the last push of the group, and it lasts one cycle. In `wr_data`, record j of the group sits at bits `[j*REC_W +: REC_W]`, with j = 0 the oldest. Each record is `{tag, code}`, with the tag in the upper bits.
- R3: The coalesce buffer is empty after its burst write. A push in the same cycle as a burst write is kept as record 0 of the next burst, so back-to-back pushes every cycle lose nothing.
- R4: The first burst after reset goes to slot 0. Each later burst goes to the next slot. After slot `SLOTS-1` the slot number wraps to 0.
- R5: A lookup whose tag is present in the coalesce buffer answers with `lk_hit`=1 and the code of the newest matching buffered record. It raises `lk_done` in the cycle after the request and issues no log read.
- R6: A lookup that misses the buffer reads log slots one at a time. It starts at the most recently written slot and walks backward, wrapping from 0 to `SLOTS-1`. Within a slot, the record with the highest index wins. The walk stops at the first slot holding a match, which sets `lk_hit`=1 with that record's code.
- R7: If no match is found, the walk ends after min(bursts written, `SLOTS`) reads with `lk_hit`=0. This includes records overwritten by newer bursts. With no burst written yet, a buffer miss answers at once with no read.
- R8: A request presented while `lk_busy` is high is ignored. Only one `lk_done` pulse, carrying the result of the original request, is produced. `lk_done` is a one-cycle pulse after which the block is idle.
- R9: At most one log read is outstanding. A read request lasts one cycle, and no new read is issued before `rd_rvalid` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_vld | input | 1 | Record push strobe (always accepted) |
| push_tag | input | TAG_W | Line tag of the pushed record |
| push_code | input | CODE_W | Strong code of the pushed record |
| wr_vld | output | 1 | Burst write strobe |
| wr_addr | output | $clog2(SLOTS) | Log slot written by the burst |
| wr_data | output | RECS*(TAG_W+CODE_W) | Packed burst of records |
| rd_req | output | 1 | Log slot read request |
| rd_addr | output | $clog2(SLOTS) | Log slot to read |
| rd_rvalid | input | 1 | Read data valid |
| rd_rdata | input | RECS*(TAG_W+CODE_W) | Read burst contents |
| lk_req | input | 1 | Lookup request |
| lk_tag | input | TAG_W | Tag to look up |
| lk_busy | output | 1 | Lookup in progress |
| lk_done | output | 1 | Lookup result valid (one cycle) |
| lk_hit | output | 1 | Matching record found |
| lk_code | output | CODE_W | Code of the matching record |

## Verification
The bench builds the block with TAG_W=12, CODE_W=8, RECS=4 and SLOTS=4. The ring therefore holds only sixteen records. Thirty pushes are enough to wrap the slot pointer to zero and to overwrite the first burst, which brings the overwritten-record miss and the full-depth walk of R7 within reach. Duplicate tags are placed inside one burst, across bursts, and in the buffer. This exercises the newest-first order of both search stages, and a memory model with one-cycle latency answers the read port.

// File: rtl/ecl_pkg.sv
package ecl_pkg;
  typedef enum logic [1:0] {
    LK_IDLE = 2'd0,
    LK_READ = 2'd1,
    LK_WAIT = 2'd2,
    LK_RESP = 2'd3
  } lk_state_e;
endpackage

// File: rtl/ecl_coalesce.sv
module ecl_coalesce #(
  parameter int TAG_W  = 16,
  parameter int CODE_W = 16,
  parameter int RECS   = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             push_vld,
  input  logic [TAG_W-1:0]                 push_tag,
  input  logic [CODE_W-1:0]                push_code,
  output logic                             full,
  output logic [$clog2(RECS+1)-1:0]        cnt,
  output logic [RECS*(TAG_W+CODE_W)-1:0]   recs_flat
);
  localparam int REC_W = TAG_W + CODE_W;
  localparam int CNT_W = $clog2(RECS + 1);
  localparam int IDX_W = (RECS > 1) ? $clog2(RECS) : 1;

  logic [CNT_W-1:0] cnt_q, cnt_d, base;
  logic [IDX_W-1:0] wr_idx;
  logic [REC_W-1:0] rec_q [RECS];

  // next-state: a full buffer is drained this cycle, so a push lands in slot 0
  always_comb begin
    full   = (cnt_q == CNT_W'(RECS));
    base   = full ? '0 : cnt_q;
    wr_idx = base[IDX_W-1:0];
    cnt_d  = base + CNT_W'(push_vld);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  for (genvar j = 0; j < RECS; j++) begin : g_rec
    always_ff @(posedge clk) begin
      if (push_vld && (wr_idx == IDX_W'(j))) rec_q[j] <= {push_tag, push_code};
    end
    assign recs_flat[j*REC_W +: REC_W] = rec_q[j];
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/ecl_ring.sv
module ecl_ring #(
  parameter int SLOTS = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          adv,
  output logic [$clog2(SLOTS)-1:0]      wptr,
  output logic [$clog2(SLOTS)-1:0]      last_slot,
  output logic [$clog2(SLOTS+1)-1:0]    nfill
);
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int FILL_W = $clog2(SLOTS + 1);

  logic [SLOT_W-1:0] wptr_q, wptr_d;
  logic [FILL_W-1:0] fill_q, fill_d;

  always_comb begin
    wptr_d = wptr_q;
    fill_d = fill_q;
    if (adv) begin
      wptr_d = (wptr_q == SLOT_W'(SLOTS - 1)) ? '0 : wptr_q + 1'b1;
      if (fill_q != FILL_W'(SLOTS)) fill_d = fill_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      fill_q <= '0;
    end else if (adv) begin
      wptr_q <= wptr_d;
      fill_q <= fill_d;
    end
  end

  assign wptr      = wptr_q;
  assign last_slot = (wptr_q == '0) ? SLOT_W'(SLOTS - 1) : wptr_q - 1'b1;
  assign nfill     = fill_q;
endmodule

// File: rtl/ecl_lookup.sv
module ecl_lookup
  import ecl_pkg::*;
#(
  parameter int TAG_W  = 16,
  parameter int CODE_W = 16,
  parameter int RECS   = 4,
  parameter int SLOTS  = 16
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             lk_req,
  input  logic [TAG_W-1:0]                 lk_tag,
  input  logic [RECS*(TAG_W+CODE_W)-1:0]   buf_flat,
  input  logic [$clog2(RECS+1)-1:0]        buf_cnt,
  input  logic [$clog2(SLOTS)-1:0]         last_slot,
  input  logic [$clog2(SLOTS+1)-1:0]       nfill,
  input  logic                             rd_rvalid,
  input  logic [RECS*(TAG_W+CODE_W)-1:0]   rd_rdata,
  output logic                             rd_req,
  output logic [$clog2(SLOTS)-1:0]         rd_addr,
  output logic                             lk_busy,
  output logic                             lk_done,
  output logic                             lk_hit,
  output logic [CODE_W-1:0]                lk_code
);
  localparam int REC_W  = TAG_W + CODE_W;
  localparam int CNT_W  = $clog2(RECS + 1);
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int FILL_W = $clog2(SLOTS + 1);

  lk_state_e         st_q, st_d;
  logic [TAG_W-1:0]  tag_q, tag_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [FILL_W-1:0] left_q, left_d;
  logic              hit_q, hit_d;
  logic [CODE_W-1:0] code_q, code_d;

  logic              b_hit, m_hit;
  logic [CODE_W-1:0] b_code, m_code;

  // buffer scan: ascending order so the highest (newest) valid match wins
  always_comb begin
    b_hit  = 1'b0;
    b_code = '0;
    for (int j = 0; j < RECS; j++) begin
      if ((CNT_W'(j) < buf_cnt) &&
          (buf_flat[j*REC_W + CODE_W +: TAG_W] == lk_tag)) begin
        b_hit  = 1'b1;
        b_code = buf_flat[j*REC_W +: CODE_W];
      end
    end
  end

  // read-data scan against the captured tag, same newest-wins order
  always_comb begin
    m_hit  = 1'b0;
    m_code = '0;
    for (int j = 0; j < RECS; j++) begin
      if (rd_rdata[j*REC_W + CODE_W +: TAG_W] == tag_q) begin
        m_hit  = 1'b1;
        m_code = rd_rdata[j*REC_W +: CODE_W];
      end
    end
  end

  always_comb begin
    st_d   = st_q;
    tag_d  = tag_q;
    slot_d = slot_q;
    left_d = left_q;
    hit_d  = hit_q;
    code_d = code_q;
    unique case (st_q)
      LK_IDLE: begin
        if (lk_req) begin
          tag_d = lk_tag;
          if (b_hit) begin
            hit_d  = 1'b1;
            code_d = b_code;
            st_d   = LK_RESP;
          end else if (nfill == '0) begin
            hit_d  = 1'b0;
            code_d = '0;
            st_d   = LK_RESP;
          end else begin
            slot_d = last_slot;
            left_d = nfill;
            st_d   = LK_READ;
          end
        end
      end
      LK_READ: st_d = LK_WAIT;
      LK_WAIT: begin
        if (rd_rvalid) begin
          if (m_hit) begin
            hit_d  = 1'b1;
            code_d = m_code;
            st_d   = LK_RESP;
          end else if (left_q == FILL_W'(1)) begin
            hit_d  = 1'b0;
            code_d = '0;
            st_d   = LK_RESP;
          end else begin
            left_d = left_q - 1'b1;
            slot_d = (slot_q == '0) ? SLOT_W'(SLOTS - 1) : slot_q - 1'b1;
            st_d   = LK_READ;
          end
        end
      end
      LK_RESP: st_d = LK_IDLE;
      default: st_d = LK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= LK_IDLE;
      hit_q  <= 1'b0;
      code_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_d == LK_RESP) begin
        hit_q  <= hit_d;
        code_q <= code_d;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (st_q == LK_IDLE && lk_req) tag_q <= tag_d;
    if (st_d == LK_READ) begin
      slot_q <= slot_d;
      left_q <= left_d;
    end
  end

  assign rd_req  = (st_q == LK_READ);
  assign rd_addr = slot_q;
  assign lk_busy = (st_q != LK_IDLE);
  assign lk_done = (st_q == LK_RESP);
  assign lk_hit  = hit_q;
  assign lk_code = code_q;
endmodule

// File: rtl/ecc_log_coalescer.sv
module ecc_log_coalescer #(
  parameter int TAG_W  = 16,
  parameter int CODE_W = 16,
  parameter int RECS   = 4,
  parameter int SLOTS  = 16
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             push_vld,
  input  logic [TAG_W-1:0]                 push_tag,
  input  logic [CODE_W-1:0]                push_code,
  output logic                             wr_vld,
  output logic [$clog2(SLOTS)-1:0]         wr_addr,
  output logic [RECS*(TAG_W+CODE_W)-1:0]   wr_data,
  output logic                             rd_req,
  output logic [$clog2(SLOTS)-1:0]         rd_addr,
  input  logic                             rd_rvalid,
  input  logic [RECS*(TAG_W+CODE_W)-1:0]   rd_rdata,
  input  logic                             lk_req,
  input  logic [TAG_W-1:0]                 lk_tag,
  output logic                             lk_busy,
  output logic                             lk_done,
  output logic                             lk_hit,
  output logic [CODE_W-1:0]                lk_code
);
  localparam int REC_W   = TAG_W + CODE_W;
  localparam int BURST_W = RECS * REC_W;
  localparam int CNT_W   = $clog2(RECS + 1);
  localparam int SLOT_W  = $clog2(SLOTS);
  localparam int FILL_W  = $clog2(SLOTS + 1);

  // reset asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic               full;
  logic [CNT_W-1:0]   buf_cnt;
  logic [BURST_W-1:0] buf_flat;
  logic [SLOT_W-1:0]  wptr, last_slot;
  logic [FILL_W-1:0]  nfill;

  ecl_coalesce #(.TAG_W(TAG_W), .CODE_W(CODE_W), .RECS(RECS)) u_coalesce (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .push_vld  (push_vld),
    .push_tag  (push_tag),
    .push_code (push_code),
    .full      (full),
    .cnt       (buf_cnt),
    .recs_flat (buf_flat)
  );

  ecl_ring #(.SLOTS(SLOTS)) u_ring (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .adv       (full),
    .wptr      (wptr),
    .last_slot (last_slot),
    .nfill     (nfill)
  );

  ecl_lookup #(.TAG_W(TAG_W), .CODE_W(CODE_W), .RECS(RECS), .SLOTS(SLOTS)) u_lookup (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .lk_req    (lk_req),
    .lk_tag    (lk_tag),
    .buf_flat  (buf_flat),
    .buf_cnt   (buf_cnt),
    .last_slot (last_slot),
    .nfill     (nfill),
    .rd_rvalid (rd_rvalid),
    .rd_rdata  (rd_rdata),
    .rd_req    (rd_req),
    .rd_addr   (rd_addr),
    .lk_busy   (lk_busy),
    .lk_done   (lk_done),
    .lk_hit    (lk_hit),
    .lk_code   (lk_code)
  );

  assign wr_vld  = full;
  assign wr_addr = wptr;
  assign wr_data = buf_flat;
endmodule

// File: rtl/ecl_checker.sv
module ecl_checker #(
  parameter int SLOTS = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     wr_vld,
  input logic [$clog2(SLOTS)-1:0] wr_addr,
  input logic                     rd_req,
  input logic                     rd_rvalid,
  input logic                     lk_busy,
  input logic                     lk_done
);
  localparam int SLOT_W = $clog2(SLOTS);

  AST_BURST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_vld |=> !wr_vld); // R2

  AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_vld && wr_addr == SLOT_W'(SLOTS - 1)) |=> (wr_addr == '0)); // R4

  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_vld && wr_addr != SLOT_W'(SLOTS - 1)) |=> (wr_addr == SLOT_W'($past(wr_addr) + 1'b1))); // R4

  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_vld |=> $stable(wr_addr)); // R4

  AST_READ_IN_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (lk_busy && !lk_done)); // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    lk_done |=> (!lk_done && !lk_busy)); // R8

  AST_READ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req); // R9

  AST_NO_READ_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rvalid |-> !rd_req); // R9
endmodule

bind ecc_log_coalescer ecl_checker #(.SLOTS(SLOTS)) u_ecl_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_vld    (wr_vld),
  .wr_addr   (wr_addr),
  .rd_req    (rd_req),
  .rd_rvalid (rd_rvalid),
  .lk_busy   (lk_busy),
  .lk_done   (lk_done)
);

// File: tb/test_ecc_log_coalescer.sv
module test_ecc_log_coalescer;
  localparam int TW = 12;
  localparam int CW = 8;
  localparam int NR = 4;
  localparam int NS = 4;
  localparam int RW = TW + CW;
  localparam int BW = NR * RW;
  localparam int SW = $clog2(NS);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          push_vld = 1'b0;
  logic [TW-1:0] push_tag = '0;
  logic [CW-1:0] push_code = '0;
  logic          wr_vld;
  logic [SW-1:0] wr_addr;
  logic [BW-1:0] wr_data;
  logic          rd_req;
  logic [SW-1:0] rd_addr;
  logic          rd_rvalid;
  logic [BW-1:0] rd_rdata;
  logic          lk_req = 1'b0;
  logic [TW-1:0] lk_tag = '0;
  logic          lk_busy, lk_done, lk_hit;
  logic [CW-1:0] lk_code;

  int checks = 0;
  int errors = 0;
  int npush = 0;
  int nburst_seen = 0;
  int rd_cnt = 0;
  int done_cnt = 0;
  logic [TW-1:0] ref_tag [256];
  logic [CW-1:0] ref_code [256];
  logic [BW-1:0] mem [NS];

  always #5 clk = ~clk;

  ecc_log_coalescer #(.TAG_W(TW), .CODE_W(CW), .RECS(NR), .SLOTS(NS)) i_ecc_log_coalescer (
    .clk(clk), .rst_n(rst_n), .push_vld(push_vld), .push_tag(push_tag), .push_code(push_code),
    .wr_vld(wr_vld), .wr_addr(wr_addr), .wr_data(wr_data), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_rvalid(rd_rvalid), .rd_rdata(rd_rdata), .lk_req(lk_req), .lk_tag(lk_tag),
    .lk_busy(lk_busy), .lk_done(lk_done), .lk_hit(lk_hit), .lk_code(lk_code)
  );

  // external memory model: one-cycle read latency
  always @(posedge clk) begin
    if (!rst_n) rd_rvalid <= 1'b0;
    else begin
      if (wr_vld) mem[wr_addr] <= wr_data;
      rd_rvalid <= rd_req;
      if (rd_req) rd_rdata <= mem[rd_addr];
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // burst, read and done monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_vld) begin
        logic [BW-1:0] exp_d;
        for (int j = 0; j < NR; j++)
          exp_d[j*RW +: RW] = {ref_tag[nburst_seen*NR + j], ref_code[nburst_seen*NR + j]};
        chk(wr_data == exp_d, "R2", "burst packing", longint'(wr_data), longint'(exp_d));
        chk(int'(wr_addr) == nburst_seen % NS, "R4", "burst slot",
            longint'(wr_addr), longint'(nburst_seen % NS));
        chk(npush >= (nburst_seen + 1) * NR, "R2", "burst before group complete",
            longint'(npush), longint'((nburst_seen + 1) * NR));
        nburst_seen++;
      end
      if (rd_req) rd_cnt++;
      if (lk_done) done_cnt++;
    end
  end

  task automatic push_seq(input logic [TW-1:0] t, input logic [CW-1:0] c);
    push_vld  = 1'b1;
    push_tag  = t;
    push_code = c;
    ref_tag[npush]  = t;
    ref_code[npush] = c;
    npush++;
    @(negedge clk);
    push_vld = 1'b0;
  endtask

  task automatic expect_lookup(input logic [TW-1:0] t, output bit hit,
                               output logic [CW-1:0] code, output int reads);
    int nb, lo;
    nb = npush / NR;
    lo = (nb > NS) ? (nb - NS) * NR : 0;
    hit = 1'b0; code = '0; reads = (nb < NS) ? nb : NS;
    for (int i = npush - 1; i >= lo; i--) begin
      if (ref_tag[i] == t) begin
        hit = 1'b1;
        code = ref_code[i];
        reads = (i >= nb * NR) ? 0 : (nb - 1 - i / NR) + 1;
        break;
      end
    end
  endtask

  task automatic lookup(input logic [TW-1:0] t, input string req);
    bit ehit; logic [CW-1:0] ecode; int ereads; int r0; int lat;
    expect_lookup(t, ehit, ecode, ereads);
    r0 = rd_cnt;
    lk_req = 1'b1; lk_tag = t;
    @(negedge clk);
    lk_req = 1'b0;
    lat = 1;
    while (!lk_done && lat < 200) begin @(negedge clk); lat++; end
    chk(lk_done == 1'b1, req, "lookup done", longint'(lk_done), 1);
    chk(lk_hit == ehit, req, "lookup hit", longint'(lk_hit), longint'(ehit));
    if (ehit) chk(lk_code == ecode, req, "lookup code", longint'(lk_code), longint'(ecode));
    chk(rd_cnt - r0 == ereads, req, "log reads", longint'(rd_cnt - r0), longint'(ereads));
    if (ehit && ereads == 0) chk(lat == 1, "R5", "buffer hit latency", longint'(lat), 1);
    @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(!wr_vld && !rd_req && !lk_busy && !lk_done, "R1", "outputs in reset",
        longint'({wr_vld, rd_req, lk_busy, lk_done}), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!wr_vld && !rd_req && !lk_busy && !lk_done, "R1", "outputs after reset",
        longint'({wr_vld, rd_req, lk_busy, lk_done}), 0);
  endtask

  task automatic t_empty_miss();
    lookup(12'hABC, "R7");
  endtask

  task automatic t_fill();
    for (int i = 0; i < NR; i++) push_seq(TW'(12'h101 + i), CW'(8'h11 + i));
    repeat (3) @(negedge clk);
    chk(nburst_seen == 1, "R2", "one burst after group", longint'(nburst_seen), 1);
  endtask

  task automatic t_back_to_back();
    logic [TW-1:0] tg [8] = '{12'h2AA, 12'h202, 12'h2AA, 12'h204,
                              12'h101, 12'h206, 12'h207, 12'h208};
    push_vld = 1'b1;
    for (int i = 0; i < 8; i++) begin
      push_tag = tg[i]; push_code = CW'(8'h21 + i);
      ref_tag[npush] = tg[i]; ref_code[npush] = CW'(8'h21 + i); npush++;
      @(negedge clk);
    end
    push_vld = 1'b0;
    repeat (4) @(negedge clk);
    chk(nburst_seen == 3, "R3", "bursts with no record dropped", longint'(nburst_seen), 3);
  endtask

  task automatic t_buffer_hit();
    push_seq(12'h3CC, 8'h31);
    push_seq(12'h3CC, 8'h32);
    lookup(12'h3CC, "R5");
  endtask

  task automatic t_log_hits();
    lookup(12'h101, "R6");
    lookup(12'h2AA, "R6");
    lookup(12'h104, "R6");
    lookup(12'h777, "R7");
  endtask

  task automatic t_busy_ignore();
    int d0;
    d0 = done_cnt;
    lk_req = 1'b1; lk_tag = 12'h104;
    @(negedge clk);
    lk_tag = 12'h3CC;
    @(negedge clk);
    lk_req = 1'b0;
    repeat (20) @(negedge clk);
    chk(done_cnt - d0 == 1, "R8", "single done for busy request", longint'(done_cnt - d0), 1);
    chk(lk_hit == 1'b1 && lk_code == 8'h14, "R8", "result of first request",
        longint'({lk_hit, lk_code}), longint'({1'b1, 8'h14}));
  endtask

  task automatic t_wrap();
    for (int i = 0; i < 4 * NS; i++) push_seq(TW'(12'h400 + i), CW'(8'h40 + i));
    repeat (3) @(negedge clk);
    chk(nburst_seen == 7, "R4", "bursts after wrap", longint'(nburst_seen), 7);
    lookup(12'h104, "R7");
    lookup(12'h3CC, "R6");
    lookup(12'h400, "R6");
    lookup(12'h40F, "R5");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_empty_miss();
    t_fill();
    t_back_to_back();
    t_buffer_hit();
    t_log_hits();
    t_busy_ignore();
    t_wrap();
    repeat (5) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule